// File: doc/BRIEF.md
# LIN Bit-Time Timeout and Output-Compare Timer

This block is the timer of a LIN controller. An 8-bit counter advances once per bit-time tick from the baud generator. It runs in one of two functions. In LIN timeout mode, hardware starts the counter when a frame header begins. It stops and zeroes the counter when the frame ends, and a compare match can send the frame state machine back to idle. In output-compare mode, software owns the counter enable and the compare value, and a match only raises a sticky flag.

Software reaches two 32-bit registers through a single-cycle write port and a combinational read port. The control/status register holds the live counter, the enable, the idle-on-timeout option, the mode select and the compare flag. The compare register holds the match value. The block also reports when the integer baud divider is too small for the counter to be accurate.

Control/status layout, LSB-0: [7:0] counter (read-only), [8] enable, [9] idle-on-timeout, [10] mode (0 = LIN timeout, 1 = output compare), [11] compare flag (write 1 to clear). All other bits are reserved. Compare register layout: [7:0] compare value, other bits reserved.

Top module: `lin_timeout_timer`

## Requirements
- R1: After reset, the control/status register reads 0x0000_0200 (idle-on-timeout set, everything else zero), the compare register reads 0, and the idle request is low.
- R2: While enable is 1, each cycle with bit_tick high adds one to the counter, and 255 wraps to 0. While enable is 0, the counter holds its value.
- R3: A write to the control/status register changes the mode bit [10] only when init_mode is high. At other times the mode bit keeps its value.
- R4: The idle-on-timeout bit [9] can be written at any time. to_idle pulses for exactly one cycle, in the cycle after a compare event, only if the mode is 0 and bit [9] is 1 at the event.
- R5: A compare event is a tick, with enable 1, while the counter equals the compare value. It sets the flag (bit [11] and oc_flag) in the next cycle. When enable is 0, no event occurs and the flag stays clear.
- R6: The flag stays set until the control/status register is written with bit [11] = 1. Writing 0 to bit [11] leaves the flag unchanged. If a compare event and a clearing write occur in the same cycle, the flag ends up set.
- R7: The hardware owns the enable bit while the mode is 0 and lin_state_init is low. In that state, software writes to bit [8] are ignored, hdr_start sets enable, and frame_done clears enable and zeroes the counter. frame_done wins if both are high. In every other state, a write to the control/status register loads bit [8].
- R8: The compare register takes bits [7:0] of a write only when the mode bit is 1. In LIN mode, writes to it are ignored.
- R9: Reserved bits read as zero in both registers, whatever value was written.
- R10: div_low is high exactly when baud_div is 5 or less.
- R11: reg_rdata shows the control/status register when reg_sel is 0 and the compare register when reg_sel is 1, with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe, one cycle |
| reg_sel | input | 1 | 0 = control/status, 1 = compare |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register |
| init_mode | input | 1 | Controller is in initialization mode |
| lin_state_init | input | 1 | LIN state machine is in its INIT state |
| hdr_start | input | 1 | Frame header has started (pulse) |
| frame_done | input | 1 | Frame has completed (pulse) |
| bit_tick | input | 1 | One pulse per bit time |
| baud_div | input | DIV_W | Integer baud divider in use |
| div_low | output | 1 | Divider too small for an accurate counter |
| oc_flag | output | 1 | Sticky compare flag |
| to_idle | output | 1 | One-cycle request to return the LIN state machine to idle |

## Verification
The bench builds the block with an 8-bit counter and an 8-bit divider input, so both value spaces can be swept completely. It drives the counter through more than one full wrap. It programs every one of the 256 compare values and checks that the flag stays clear up to the matching tick and is set right after it. It also applies every divider value to the low-divider output. The mode-dependent write permissions and the hardware takeover of the enable bit are exercised with writes that must be ignored, each followed by a readback of the affected field.

// File: rtl/lin_tmr_pkg.sv
package lin_tmr_pkg;
  // control/status bit positions (LSB-0)
  localparam int F_EN   = 8;
  localparam int F_IOT  = 9;
  localparam int F_MODE = 10;
  localparam int F_OCF  = 11;

  typedef enum logic {
    MODE_LIN = 1'b0,
    MODE_OC  = 1'b1
  } tmr_mode_e;
endpackage

// File: rtl/lin_tmr_cfg.sv
module lin_tmr_cfg
  import lin_tmr_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_ctrl,
  input  logic             wr_cmp,
  input  logic [31:0]      wdata,
  input  logic             init_mode,
  input  logic             lin_state_init,
  input  logic             hdr_start,
  input  logic             frame_done,
  output tmr_mode_e        mode_q,
  output logic             iot_q,
  output logic             en_q,
  output logic [CNT_W-1:0] cmp_q,
  output logic             cnt_clr
);
  tmr_mode_e        mode_d;
  logic             iot_d, en_d, hw_ctrl;
  logic [CNT_W-1:0] cmp_d;

  assign hw_ctrl = (mode_q == MODE_LIN) && !lin_state_init;
  assign cnt_clr = hw_ctrl && frame_done;

  always_comb begin
    mode_d = mode_q;
    if (wr_ctrl && init_mode) mode_d = tmr_mode_e'(wdata[F_MODE]);
    iot_d = wr_ctrl ? wdata[F_IOT] : iot_q;
    en_d = en_q;
    if (hw_ctrl) begin
      if (frame_done)     en_d = 1'b0;
      else if (hdr_start) en_d = 1'b1;
    end else if (wr_ctrl) begin
      en_d = wdata[F_EN];
    end
    cmp_d = cmp_q;
    if (wr_cmp && (mode_q == MODE_OC)) cmp_d = wdata[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_LIN;
      iot_q  <= 1'b1;
      en_q   <= 1'b0;
      cmp_q  <= '0;
    end else begin
      mode_q <= mode_d;
      iot_q  <= iot_d;
      en_q   <= en_d;
      cmp_q  <= cmp_d;
    end
  end

  // R3: mode is frozen outside initialization
  a_r3_mode_locked: assert property (@(posedge clk) disable iff (!rst_n)
    !init_mode |=> $stable(mode_q));
  // R8: compare value frozen in LIN mode
  a_r8_cmp_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_LIN) |=> $stable(cmp_q));
  // R7: software cannot move enable while hardware owns it
  a_r7_hw_owns_en: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_LIN && !lin_state_init && !hdr_start && !frame_done) |=> $stable(en_q));
  // R7: frame completion stops the counter
  a_r7_done_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_LIN && !lin_state_init && frame_done) |=> !en_q);
endmodule

// File: rtl/lin_tmr_count.sv
module lin_tmr_count #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             tick,
  input  logic             clr,
  input  logic [CNT_W-1:0] cmp,
  output logic [CNT_W-1:0] cnt_q,
  output logic             match_evt
);
  logic [CNT_W-1:0] cnt_d;
  logic             adv;

  assign adv       = en && tick;
  assign match_evt = adv && (cnt_q == cmp);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)      cnt_d = '0;
    else if (adv) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R2: disabled counter holds
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !clr) |=> $stable(cnt_q));
  // R2: wrap from all-ones to zero
  a_r2_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tick && !clr && (&cnt_q)) |=> (cnt_q == '0));
endmodule

// File: rtl/lin_timeout_timer.sv
module lin_timeout_timer
  import lin_tmr_pkg::*;
#(
  parameter int CNT_W         = 8,
  parameter int DIV_W         = 16,
  parameter int LOW_DIV_LIMIT = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr_en,
  input  logic             reg_sel,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic             init_mode,
  input  logic             lin_state_init,
  input  logic             hdr_start,
  input  logic             frame_done,
  input  logic             bit_tick,
  input  logic [DIV_W-1:0] baud_div,
  output logic             div_low,
  output logic             oc_flag,
  output logic             to_idle
);
  localparam logic [DIV_W-1:0] DIV_LIM = DIV_W'(LOW_DIV_LIMIT);

  tmr_mode_e        mode;
  logic             iot, en, cnt_clr, match_evt;
  logic [CNT_W-1:0] cmp, cnt;
  logic             wr_ctrl, wr_cmp, ocf_clr;
  logic             ocf_d, ocf_q, idle_d, idle_q;

  assign wr_ctrl = reg_wr_en && !reg_sel;
  assign wr_cmp  = reg_wr_en && reg_sel;
  assign ocf_clr = wr_ctrl && reg_wdata[F_OCF];

  lin_tmr_cfg #(.CNT_W(CNT_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wr_cmp(wr_cmp),
    .wdata(reg_wdata), .init_mode(init_mode), .lin_state_init(lin_state_init),
    .hdr_start(hdr_start), .frame_done(frame_done), .mode_q(mode),
    .iot_q(iot), .en_q(en), .cmp_q(cmp), .cnt_clr(cnt_clr)
  );

  lin_tmr_count #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .en(en), .tick(bit_tick), .clr(cnt_clr),
    .cmp(cmp), .cnt_q(cnt), .match_evt(match_evt)
  );

  always_comb begin
    ocf_d = ocf_q;
    if (match_evt)    ocf_d = 1'b1;
    else if (ocf_clr) ocf_d = 1'b0;
    idle_d = match_evt && (mode == MODE_LIN) && iot;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ocf_q  <= 1'b0;
      idle_q <= 1'b0;
    end else begin
      ocf_q  <= ocf_d;
      idle_q <= idle_d;
    end
  end

  assign oc_flag = ocf_q;
  assign to_idle = idle_q;
  assign div_low = (baud_div <= DIV_LIM);

  always_comb begin
    reg_rdata = '0;
    if (reg_sel) begin
      reg_rdata[CNT_W-1:0] = cmp;
    end else begin
      reg_rdata[CNT_W-1:0] = cnt;
      reg_rdata[F_EN]      = en;
      reg_rdata[F_IOT]     = iot;
      reg_rdata[F_MODE]    = mode;
      reg_rdata[F_OCF]     = ocf_q;
    end
  end

  // R6: flag is sticky until a clearing write
  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (oc_flag && !ocf_clr) |=> oc_flag);
  // R4: no idle request in compare mode or with the option off
  a_r4_no_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == MODE_OC) || !iot) |=> !to_idle);
  // R5: a disabled timer never raises the flag
  a_r5_no_flag_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !oc_flag) |=> !oc_flag);
  // R4: idle request lasts one cycle
  a_r4_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    to_idle |=> !to_idle);
endmodule

// File: tb/tb_lin_timeout_timer.sv
module tb_lin_timeout_timer;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n, reg_wr_en, reg_sel, init_mode, lin_state_init;
  logic        hdr_start, frame_done, bit_tick, div_low, oc_flag, to_idle;
  logic [31:0] reg_wdata, reg_rdata;
  logic [7:0]  baud_div;

  int vecs = 0, errs = 0;
  int m_cnt = 0, m_cmp = 0;
  logic m_mode = 0, m_iot = 1, m_en = 0, m_flag = 0, m_idle = 0;

  lin_timeout_timer #(.CNT_W(8), .DIV_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .init_mode(init_mode),
    .lin_state_init(lin_state_init), .hdr_start(hdr_start), .frame_done(frame_done),
    .bit_tick(bit_tick), .baud_div(baud_div), .div_low(div_low),
    .oc_flag(oc_flag), .to_idle(to_idle)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_ctrl();
    return {20'b0, m_flag, m_mode, m_iot, m_en, 8'(m_cnt)};
  endfunction

  task automatic rd(input string req, input logic sel, input logic [31:0] exp);
    reg_sel = sel;
    #1;
    chk(req, reg_rdata, exp);
  endtask

  task automatic wr(input logic sel, input logic [31:0] d);
    reg_sel = sel; reg_wdata = d; reg_wr_en = 1'b1;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  // one tick; updates the model and checks the idle request
  task automatic tick1();
    logic evt;
    evt = m_en && (m_cnt == m_cmp);
    bit_tick = 1'b1;
    @(negedge clk);
    bit_tick = 1'b0;
    if (evt) m_flag = 1'b1;
    m_idle = evt && !m_mode && m_iot;
    if (m_en) m_cnt = (m_cnt + 1) % 256;
    chk("R4 idle request", {31'b0, to_idle}, {31'b0, m_idle});
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    errs++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    rst_n = 0; reg_wr_en = 0; reg_sel = 0; reg_wdata = 0; init_mode = 0;
    lin_state_init = 1; hdr_start = 0; frame_done = 0; bit_tick = 0; baud_div = 8'd20;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state, R11 readback select
    rd("R1 ctrl reset", 1'b0, 32'h0000_0200);
    rd("R1 cmp reset", 1'b1, 32'h0);
    chk("R1 idle reset", {31'b0, to_idle}, 32'h0);

    // R3 mode locked outside init; R4 iot writable anytime
    wr(1'b0, 32'h0000_0400); m_iot = 0;
    rd("R3 mode locked", 1'b0, exp_ctrl());
    init_mode = 1;
    wr(1'b0, 32'h0000_0600); m_mode = 1; m_iot = 1;
    rd("R3 mode written in init", 1'b0, exp_ctrl());

    // R9 reserved bits
    wr(1'b0, 32'hFFFF_F600);
    rd("R9 ctrl reserved", 1'b0, exp_ctrl());
    wr(1'b1, 32'hFFFF_FF5A); m_cmp = 8'h5A;
    rd("R9 R8 cmp reserved", 1'b1, 32'h5A);

    // R2 counting with wrap
    wr(1'b0, 32'h0000_0700); m_en = 1;
    for (int i = 0; i < 300; i++) begin
      tick1();
      rd("R2 count", 1'b0, exp_ctrl());
    end

    // R5 sweep every compare value
    for (int c = 0; c < 256; c++) begin
      wr(1'b1, 32'(c)); m_cmp = c;
      wr(1'b0, 32'h0000_0F00); m_flag = 0;
      while (m_cnt != c) tick1();
      chk("R5 flag before match", {31'b0, oc_flag}, 32'h0);
      tick1();
      chk("R5 flag after match", {31'b0, oc_flag}, 32'h1);
    end

    // R6 sticky, write-0 no effect, w1c, set wins
    tick1(); tick1();
    chk("R6 sticky", {31'b0, oc_flag}, 32'h1);
    wr(1'b0, 32'h0000_0700);
    chk("R6 write zero keeps", {31'b0, oc_flag}, 32'h1);
    wr(1'b0, 32'h0000_0F00); m_flag = 0;
    chk("R6 w1c", {31'b0, oc_flag}, 32'h0);
    wr(1'b1, 32'(m_cnt)); m_cmp = m_cnt;
    reg_sel = 0; reg_wdata = 32'h0000_0F00; reg_wr_en = 1; bit_tick = 1;
    @(negedge clk);
    reg_wr_en = 0; bit_tick = 0; m_flag = 1; m_cnt = (m_cnt + 1) % 256;
    rd("R6 set wins", 1'b0, exp_ctrl());

    // R2 hold and R5 no flag when disabled
    wr(1'b0, 32'h0000_0E00); m_en = 0; m_flag = 0;
    wr(1'b1, 32'(m_cnt)); m_cmp = m_cnt;
    for (int i = 0; i < 10; i++) tick1();
    rd("R2 R5 disabled hold", 1'b0, exp_ctrl());

    // R8 compare locked in LIN mode
    wr(1'b1, 32'd20); m_cmp = 20;
    wr(1'b0, 32'h0000_0200); m_mode = 0;
    wr(1'b1, 32'd99);
    rd("R8 cmp locked", 1'b1, 32'd20);

    // R7 software enable in LIN INIT, then hardware takeover
    wr(1'b0, 32'h0000_0300); m_en = 1;
    rd("R7 sw enable", 1'b0, exp_ctrl());
    init_mode = 0; lin_state_init = 0;
    wr(1'b0, 32'h0000_0200);
    rd("R7 sw write ignored", 1'b0, exp_ctrl());
    frame_done = 1; hdr_start = 1;
    @(negedge clk);
    frame_done = 0; hdr_start = 0; m_en = 0; m_cnt = 0;
    rd("R7 frame done wins", 1'b0, exp_ctrl());
    hdr_start = 1;
    @(negedge clk);
    hdr_start = 0; m_en = 1;
    rd("R7 header start", 1'b0, exp_ctrl());

    // R4 timeout request in LIN mode
    for (int i = 0; i < 21; i++) tick1();
    chk("R4 pulse seen", {31'b0, to_idle}, 32'h1);
    @(negedge clk); m_idle = 0;
    chk("R4 pulse ends", {31'b0, to_idle}, 32'h0);

    // R4 option off: flag only
    wr(1'b0, 32'h0000_0800); m_iot = 0; m_flag = 0;
    frame_done = 1; @(negedge clk); frame_done = 0; m_en = 0; m_cnt = 0;
    hdr_start = 1; @(negedge clk); hdr_start = 0; m_en = 1;
    for (int i = 0; i < 21; i++) tick1();
    rd("R4 R5 no idle with option off", 1'b0, exp_ctrl());

    // R10 every divider value
    for (int d = 0; d < 256; d++) begin
      baud_div = 8'(d);
      #1;
      chk("R10 divider low", {31'b0, div_low}, {31'b0, (d <= 5)});
    end

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule